// File: doc/BRIEF.md
# Four-Way Set-Associative Address Translation Lookup

This block translates 32-bit virtual addresses to physical addresses for external instruction fetches and data accesses. It holds translation entries in four ways of 32 sets each. A lookup picks one set in every way from virtual address bits 16..12 and compares the four selected entries at once. A single registered result comes out the following clock: a hit flag, the one-hot number of the way that matched, the physical address and the protection, cacheable and dirty attributes of that entry.

The match rule differs from entry to entry. Each entry has a page-size flag. For a small page (1 KB), two low page-number bits take part in the compare. For a large page (4 KB), they do not. Each entry also has a shared flag, and a shared entry matches any current address-space identifier. A mode input selects single-virtual-space operation, in which no entry checks the identifier. Entries are filled through a simple write port, one per clock. A synchronous flush input invalidates every entry at once. Software must never set up entries so that two ways match the same lookup.

Top module: `tlb_lookup`

## Requirements
- R1: While `rst_n` is low, all outputs are zero and every entry becomes invalid. After reset, no lookup hits until an entry has been written with `wr_valid`=1.
- R2: A way hits only if four conditions hold: its selected entry is valid, its stored `lk_va[31:17]` tag equals the request's, its low-page-bit rule (R3) passes and its identifier rule (R4, R5) passes. `hit_way` bit i stands for way i, and `hit` is high exactly when one bit is set.
- R3: An entry written with `wr_sz`=0 (1 KB page) also requires its stored 2-bit low tag to equal `lk_va[11:10]`. An entry with `wr_sz`=1 (4 KB page) ignores those bits.
- R4: When `single_vm`=0, an entry with `wr_shared`=0 also requires its stored 8-bit identifier to equal `cur_asid`. An entry with `wr_shared`=1 matches any `cur_asid`.
- R5: When `single_vm`=1, `cur_asid` and the stored identifier are ignored for every entry.
- R6: On a hit, `pr_out`, `cach_out` and `dirty_out` are the stored fields of the matching entry. For a 1 KB page, `pa` = {ppn[21:0], lk_va[9:0]}. For a 4 KB page, `pa` = {ppn[21:2], lk_va[11:0]}.
- R7: A high `flush_all` at a clock edge invalidates every entry, including one written at that same edge. A lookup issued in any later cycle misses until entries are rewritten.
- R8: The result of a request in cycle n is registered at the edge ending cycle n. In a cycle without `lk_req`, or on a miss, `hit`, `hit_way`, `pa`, `pr_out`, `cach_out` and `dirty_out` all become zero.
- R9: With `wr_en`=1, the entry at (`wr_way`, `wr_idx`) is replaced at the clock edge. A lookup in the same cycle sees the old contents, and a lookup in the next cycle sees the new contents.
- R10: The set is selected by `lk_va[16:12]`. An entry written at one index never matches a lookup whose index differs, even when the tags are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every entry |
| single_vm | input | 1 | 1 = skip identifier check for all entries |
| cur_asid | input | 8 | Current address-space identifier |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| wr_en | input | 1 | Write one entry |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 5 | Set to write |
| wr_vpn_hi | input | 15 | Tag, virtual address bits 31..17 |
| wr_vpn_lo | input | 2 | Low tag, virtual address bits 11..10 |
| wr_asid | input | 8 | Stored identifier |
| wr_valid | input | 1 | Valid flag to store |
| wr_ppn | input | 22 | Physical page number, bits 31..10 |
| wr_pr | input | 2 | Protection field |
| wr_sz | input | 1 | 0 = 1 KB page, 1 = 4 KB page |
| wr_cach | input | 1 | Cacheable flag |
| wr_dirty | input | 1 | Dirty flag |
| wr_shared | input | 1 | Shared flag |
| hit | output | 1 | Registered hit |
| hit_way | output | 4 | One-hot matching way |
| pa | output | 32 | Physical address |
| pr_out | output | 2 | Protection of matching entry |
| cach_out | output | 1 | Cacheable flag of matching entry |
| dirty_out | output | 1 | Dirty flag of matching entry |

## Verification
A lookup result is due at the rising edge that ends the request cycle. A write or flush changes only lookups issued in the next cycle or later. The bench drives every input on the falling edge and advances its behavioural model at the rising edge: the model first forms the lookup from its pre-edge table and then applies the write and the flush. The bench compares all outputs with the model at the next falling edge. The case of a write and a lookup in the same cycle, and the case of a write and a flush at the same edge, are therefore judged at the exact cycle the change becomes visible.

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int WAYS  = 4,
  parameter int IDX_W = 5,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int HI_W  = 20 - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_all,
  input  logic             single_vm,
  input  logic [7:0]       cur_asid,
  input  logic             lk_req,
  input  logic [31:0]      lk_va,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [HI_W-1:0]  wr_vpn_hi,
  input  logic [1:0]       wr_vpn_lo,
  input  logic [7:0]       wr_asid,
  input  logic             wr_valid,
  input  logic [21:0]      wr_ppn,
  input  logic [1:0]       wr_pr,
  input  logic             wr_sz,
  input  logic             wr_cach,
  input  logic             wr_dirty,
  input  logic             wr_shared,
  output logic             hit,
  output logic [WAYS-1:0]  hit_way,
  output logic [31:0]      pa,
  output logic [1:0]       pr_out,
  output logic             cach_out,
  output logic             dirty_out
);

  localparam int SETS = 1 << IDX_W;

  logic [IDX_W-1:0] rd_idx;
  logic [HI_W-1:0]  rd_hi;
  assign rd_idx = lk_va[12 +: IDX_W];
  assign rd_hi  = lk_va[31 -: HI_W];

  logic [WAYS-1:0] way_hit, way_c, way_d;
  logic [31:0]     way_pa [WAYS];
  logic [1:0]      way_pr [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [HI_W-1:0] tag_hi   [SETS];
    logic [1:0]      tag_lo   [SETS];
    logic [7:0]      tag_asid [SETS];
    logic [21:0]     ppn      [SETS];
    logic [1:0]      prot     [SETS];
    logic [SETS-1:0] big, cach, dirty, shared, vld;
    logic sel, lo_ok, asid_ok;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_hi[wr_idx]   <= wr_vpn_hi;
        tag_lo[wr_idx]   <= wr_vpn_lo;
        tag_asid[wr_idx] <= wr_asid;
        ppn[wr_idx]      <= wr_ppn;
        prot[wr_idx]     <= wr_pr;
        big[wr_idx]      <= wr_sz;
        cach[wr_idx]     <= wr_cach;
        dirty[wr_idx]    <= wr_dirty;
        shared[wr_idx]   <= wr_shared;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || flush_all) vld <= '0;
      else if (sel)            vld[wr_idx] <= wr_valid;
    end

    assign lo_ok   = big[rd_idx] || (tag_lo[rd_idx] == lk_va[11:10]);
    assign asid_ok = single_vm || shared[rd_idx] || (tag_asid[rd_idx] == cur_asid);
    assign way_hit[w] = vld[rd_idx] && (tag_hi[rd_idx] == rd_hi) && lo_ok && asid_ok;
    assign way_pa[w]  = big[rd_idx] ? {ppn[rd_idx][21:2], lk_va[11:0]}
                                    : {ppn[rd_idx], lk_va[9:0]};
    assign way_pr[w]  = prot[rd_idx];
    assign way_c[w]   = cach[rd_idx];
    assign way_d[w]   = dirty[rd_idx];
  end

  logic [31:0] m_pa;
  logic [1:0]  m_pr;
  logic        m_c, m_d;

  always_comb begin
    m_pa = '0;
    m_pr = '0;
    m_c  = 1'b0;
    m_d  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) begin
        m_pa = m_pa | way_pa[w];
        m_pr = m_pr | way_pr[w];
        m_c  = m_c | way_c[w];
        m_d  = m_d | way_d[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit       <= 1'b0;
      hit_way   <= '0;
      pa        <= '0;
      pr_out    <= '0;
      cach_out  <= 1'b0;
      dirty_out <= 1'b0;
    end else begin
      hit       <= lk_req && (|way_hit);
      hit_way   <= lk_req ? way_hit : '0;
      pa        <= lk_req ? m_pa : '0;
      pr_out    <= lk_req ? m_pr : '0;
      cach_out  <= lk_req && m_c;
      dirty_out <= lk_req && m_d;
    end
  end

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!hit && hit_way == '0 && pa == '0));

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_way == '0 && pa == '0 && pr_out == '0 && !cach_out && !dirty_out));

  // single-way hits rely on software never loading overlapping entries
  assert_one_way_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $onehot(hit_way));

  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pa[9:0] == $past(lk_va[9:0]));

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all ##1 lk_req |=> !hit);

endmodule

// File: tb/tlb_lookup_test.sv
module tlb_lookup_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, flush_all = 1'b0, single_vm = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [4:0]  wr_idx = '0;
  logic [14:0] wr_vpn_hi = '0;
  logic [1:0]  wr_vpn_lo = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_valid = 1'b0;
  logic [21:0] wr_ppn = '0;
  logic [1:0]  wr_pr = '0;
  logic        wr_sz = 1'b0, wr_cach = 1'b0, wr_dirty = 1'b0, wr_shared = 1'b0;
  logic        hit;
  logic [3:0]  hit_way;
  logic [31:0] pa;
  logic [1:0]  pr_out;
  logic        cach_out, dirty_out;

  tlb_lookup uut (.*);

  // behavioural model
  logic [14:0] m_hi [4][32];
  logic [1:0]  m_lo [4][32];
  logic [7:0]  m_as [4][32];
  logic [21:0] m_pn [4][32];
  logic [1:0]  m_pr [4][32];
  bit          m_v  [4][32];
  bit          m_sz [4][32], m_c [4][32], m_d [4][32], m_sh [4][32];

  logic        e_hit, e_c, e_d;
  logic [3:0]  e_way;
  logic [31:0] e_pa;
  logic [1:0]  e_pr;
  int checks = 0, errors = 0;

  task automatic model_edge();
    e_hit = 0; e_way = '0; e_pa = '0; e_pr = '0; e_c = 0; e_d = 0;
    if (!rst_n) begin
      foreach (m_v[w, s]) m_v[w][s] = 0;
      return;
    end
    if (lk_req) begin
      int s = int'(lk_va[16:12]);
      for (int w = 0; w < 4; w++) begin
        bit ok = m_v[w][s] && m_hi[w][s] == lk_va[31:17]
               && (m_sz[w][s] || m_lo[w][s] == lk_va[11:10])
               && (single_vm || m_sh[w][s] || m_as[w][s] == cur_asid);
        if (ok) begin
          e_hit = 1; e_way[w] = 1'b1;
          e_pa = m_sz[w][s] ? {m_pn[w][s][21:2], lk_va[11:0]} : {m_pn[w][s], lk_va[9:0]};
          e_pr = m_pr[w][s]; e_c = m_c[w][s]; e_d = m_d[w][s];
        end
      end
    end
    if (wr_en) begin
      m_hi[wr_way][wr_idx] = wr_vpn_hi; m_lo[wr_way][wr_idx] = wr_vpn_lo;
      m_as[wr_way][wr_idx] = wr_asid;   m_pn[wr_way][wr_idx] = wr_ppn;
      m_pr[wr_way][wr_idx] = wr_pr;     m_sz[wr_way][wr_idx] = wr_sz;
      m_c[wr_way][wr_idx]  = wr_cach;   m_d[wr_way][wr_idx]  = wr_dirty;
      m_sh[wr_way][wr_idx] = wr_shared; m_v[wr_way][wr_idx]  = wr_valid;
    end
    if (flush_all) foreach (m_v[w, s]) m_v[w][s] = 0;
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if ({hit, hit_way, pa, pr_out, cach_out, dirty_out} !== {e_hit, e_way, e_pa, e_pr, e_c, e_d}) begin
      errors++;
      $display("FAIL %s: got hit=%b way=%b pa=%h pr=%0d c=%b d=%b, expected hit=%b way=%b pa=%h pr=%0d c=%b d=%b",
               tag, hit, hit_way, pa, pr_out, cach_out, dirty_out, e_hit, e_way, e_pa, e_pr, e_c, e_d);
    end
    wr_en = 0; lk_req = 0; flush_all = 0;
  endtask

  task automatic put(input logic [1:0] w, input logic [4:0] s, input logic [14:0] hi,
                     input logic [1:0] lo, input logic [7:0] as, input logic v,
                     input logic [21:0] pn, input logic [1:0] pr, input logic sz,
                     input logic c, input logic d, input logic sh);
    wr_en = 1; wr_way = w; wr_idx = s; wr_vpn_hi = hi; wr_vpn_lo = lo; wr_asid = as;
    wr_valid = v; wr_ppn = pn; wr_pr = pr; wr_sz = sz; wr_cach = c; wr_dirty = d; wr_shared = sh;
  endtask

  task automatic ask(input logic [14:0] hi, input logic [4:0] s, input logic [1:0] lo,
                     input logic [9:0] off);
    lk_req = 1; lk_va = {hi, s, lo, off};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    ask(15'h1234, 5'd3, 2'd2, 10'h155); cyc("R1");
    cyc("R1");
    rst_n = 1;
    ask(15'h0000, 5'd0, 2'd0, 10'h000); cyc("R1");
    cur_asid = 8'h12;
    // A: 1 KB private entry, way 0 set 3
    put(2'd0, 5'd3, 15'h1234, 2'd2, 8'h12, 1, 22'h2ABCD5, 2'd3, 0, 1, 0, 0); cyc("R9");
    ask(15'h1234, 5'd3, 2'd2, 10'h155); cyc("R2");
    ask(15'h1234, 5'd3, 2'd2, 10'h3FF); cyc("R6");
    ask(15'h1234, 5'd3, 2'd1, 10'h155); cyc("R3");
    cur_asid = 8'h13;
    ask(15'h1234, 5'd3, 2'd2, 10'h155); cyc("R4");
    // B: 4 KB shared entry, way 1 set 5
    put(2'd1, 5'd5, 15'h0777, 2'd0, 8'h40, 1, 22'h3F0F0F, 2'd1, 1, 0, 1, 1); cyc("R9");
    ask(15'h0777, 5'd5, 2'd3, 10'h2AA); cyc("R3");
    ask(15'h0777, 5'd5, 2'd1, 10'h001); cyc("R4");
    ask(15'h0776, 5'd5, 2'd1, 10'h001); cyc("R2");
    // single virtual space mode
    cur_asid = 8'h99; single_vm = 1;
    ask(15'h1234, 5'd3, 2'd2, 10'h0F0); cyc("R5");
    single_vm = 0;
    ask(15'h1234, 5'd3, 2'd2, 10'h0F0); cyc("R5");
    cur_asid = 8'h12;
    // write and lookup of same entry in one cycle
    put(2'd0, 5'd3, 15'h4321, 2'd2, 8'h12, 1, 22'h000111, 2'd2, 0, 0, 1, 0);
    ask(15'h1234, 5'd3, 2'd2, 10'h100); cyc("R9");
    ask(15'h1234, 5'd3, 2'd2, 10'h100); cyc("R9");
    ask(15'h4321, 5'd3, 2'd2, 10'h100); cyc("R9");
    // invalid entry never hits
    put(2'd2, 5'd7, 15'h0ABC, 2'd0, 8'h12, 0, 22'h123456, 2'd1, 1, 1, 1, 1); cyc("R2");
    ask(15'h0ABC, 5'd7, 2'd0, 10'h000); cyc("R2");
    // index selection
    put(2'd3, 5'd31, 15'h0555, 2'd1, 8'h12, 1, 22'h0CAFE0, 2'd0, 1, 1, 0, 0); cyc("R10");
    ask(15'h0555, 5'd30, 2'd1, 10'h010); cyc("R10");
    ask(15'h0555, 5'd31, 2'd1, 10'h010); cyc("R10");
    // no request gives zero outputs
    lk_va = {15'h0555, 5'd31, 2'd1, 10'h010}; cyc("R8");
    ask(15'h0FFF, 5'd31, 2'd1, 10'h010); cyc("R8");
    // flush together with a write
    put(2'd2, 5'd8, 15'h0202, 2'd0, 8'h12, 1, 22'h1, 2'd3, 1, 1, 1, 0);
    flush_all = 1; cyc("R7");
    ask(15'h0202, 5'd8, 2'd0, 10'h000); cyc("R7");
    ask(15'h4321, 5'd3, 2'd2, 10'h100); cyc("R7");
    ask(15'h0555, 5'd31, 2'd1, 10'h010); cyc("R7");
    // mixed traffic; tag bits 1:0 equal the way so at most one way matches
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] w;
      w = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0)
        put(w, 5'($urandom_range(0, 3)), {13'($urandom_range(0, 3)), w}, 2'($urandom),
            8'($urandom_range(0, 3)), 1'($urandom_range(0, 5) != 0), 22'($urandom),
            2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 4) != 0)
        ask({13'($urandom_range(0, 3)), 2'($urandom)}, 5'($urandom_range(0, 3)),
            2'($urandom), 10'($urandom));
      cur_asid = 8'($urandom_range(0, 3));
      single_vm = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 199) == 0) flush_all = 1;
      cyc("R2");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule